// File: doc/BRIEF.md
# Power-Fail Recovery Recycle Controller

This block brings a transmitter back to its earlier power level once mains power returns after a failure. Several raw supply-fault lines feed a fault stretcher. The stretcher turns on as soon as any fault appears. Once every fault is gone, it stays on for a programmable number of clock cycles before it turns off. While the stretched fault is on, three things hold. A data-clear output keeps the downstream power data registers at zero. The internal OFF command that a fault produces is sent toward the level register. The capture of that register is blocked, so the OFF command, like any operator command, is lost.

When the stretched fault releases, a one-cycle data strobe marks the end of data-clear. If the retained level register holds HIGH, MEDIUM or LOW, a one-cycle turn-on request also goes out to start the step-start sequence. The level register keeps its contents through a reset when the backup-memory flag says the backup supply is still valid. If that flag is low, the register falls back to off.

Top module: `pwr_recycle_ctrl`

## Requirements
- R1: Once any bit of `supply_fault_i` is sampled high at a clock edge, `fault_stretch_o` is high after the second rising edge from that point. The delay comes from the two-flop input synchronizer.
- R2: Once all synchronized faults are low, `fault_stretch_o` stays high for exactly `HOLD_CYCLES` further clock cycles and then falls.
- R3: A synchronized fault seen during the countdown reloads the full `HOLD_CYCLES` count.
- R4: While `fault_stretch_o` is high, `level_o` does not change. No operator command and no fault-generated OFF is stored.
- R5: While `fault_stretch_o` is low, a synchronized command is stored in `level_o` at the next edge. The priority order is OFF, then HIGH, then MEDIUM, then LOW. The encoding is 0 = off, 1 = LOW, 2 = MEDIUM, 3 = HIGH. When no command is present, the level is held.
- R6: `data_clear_o` is high exactly when `fault_stretch_o` is high.
- R7: `data_strobe_o` is high for exactly one cycle: the first cycle in which `fault_stretch_o` is low after being high.
- R8: `turn_on_req_o` is high only in that same release cycle, and only when `level_o` is not 0.
- R9: While `rst_n` is low, the stretch is loaded as active with a full count. The level becomes 0 if `backup_ok_i` is low and is retained if `backup_ok_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; while held, the clock keeps running |
| supply_fault_i | input | NUM_FAULTS | Raw supply-fault lines, high = fault |
| cmd_high_i | input | 1 | HIGH level command |
| cmd_med_i | input | 1 | MEDIUM level command |
| cmd_low_i | input | 1 | LOW level command |
| cmd_off_i | input | 1 | OFF command |
| backup_ok_i | input | 1 | Backup memory supply valid |
| fault_stretch_o | output | 1 | Stretched supply fault (fast on, slow off) |
| data_clear_o | output | 1 | Holds downstream power data registers at zero |
| data_strobe_o | output | 1 | One-cycle pulse when data-clear ends |
| turn_on_req_o | output | 1 | One-cycle turn-on request for the retained level |
| level_o | output | 2 | Retained power level, 0 off / 1 LOW / 2 MEDIUM / 3 HIGH |

## Verification
The bench builds the block with `HOLD_CYCLES = 20` and `NUM_FAULTS = 3`. With these values, every release edge and every restart of the countdown fits in a few hundred cycles. This allows exact measurement of the off delay, a fault that re-enters mid-countdown, and commands issued during both the raw-fault and the hold phases. Three resets are exercised: backup low at power-up, backup high with HIGH retained, and backup low again to confirm that the level is cleared.

// File: rtl/pwr_recycle_ctrl.sv
module pwr_recycle_ctrl #(
  parameter int NUM_FAULTS  = 4,
  parameter int HOLD_CYCLES = 500_000_000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FAULTS-1:0] supply_fault_i,
  input  logic                  cmd_high_i,
  input  logic                  cmd_med_i,
  input  logic                  cmd_low_i,
  input  logic                  cmd_off_i,
  input  logic                  backup_ok_i,
  output logic                  fault_stretch_o,
  output logic                  data_clear_o,
  output logic                  data_strobe_o,
  output logic                  turn_on_req_o,
  output logic [1:0]            level_o
);

  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYCLES);
  localparam logic [1:0] LVL_OFF = 2'd0, LVL_LOW = 2'd1, LVL_MED = 2'd2, LVL_HIGH = 2'd3;

  logic [NUM_FAULTS-1:0] flt_s1, flt_s2;
  logic [3:0]            cmd_s1, cmd_s2;
  logic [CW-1:0]         cnt_q;
  logic                  hold_q, prev_q;
  logic [1:0]            level_q;
  logic                  raw_any;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_s1 <= '0;
      flt_s2 <= '0;
      cmd_s1 <= '0;
      cmd_s2 <= '0;
    end else begin
      flt_s1 <= supply_fault_i;
      flt_s2 <= flt_s1;
      cmd_s1 <= {cmd_off_i, cmd_high_i, cmd_med_i, cmd_low_i};
      cmd_s2 <= cmd_s1;
    end

  assign raw_any = |flt_s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q  <= HOLD_V;
      hold_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      prev_q <= fault_stretch_o;
      if (raw_any) begin
        cnt_q  <= HOLD_V;
        hold_q <= 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q  <= cnt_q - 1'b1;
        hold_q <= (cnt_q != CW'(1));
      end
    end

  assign fault_stretch_o = raw_any | hold_q;
  assign data_clear_o    = fault_stretch_o;

  logic       cmd_any;
  logic [1:0] cmd_lvl;
  assign cmd_any = raw_any | (|cmd_s2);
  always_comb begin
    if (raw_any || cmd_s2[3]) cmd_lvl = LVL_OFF;
    else if (cmd_s2[2])       cmd_lvl = LVL_HIGH;
    else if (cmd_s2[1])       cmd_lvl = LVL_MED;
    else                      cmd_lvl = LVL_LOW;
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      if (!backup_ok_i) level_q <= LVL_OFF;
    end else if (!fault_stretch_o && cmd_any) begin
      level_q <= cmd_lvl;
    end

  assign level_o       = level_q;
  assign data_strobe_o = prev_q & ~fault_stretch_o;
  assign turn_on_req_o = data_strobe_o & (level_q != LVL_OFF);

  // R4
  level_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_stretch_o |=> $stable(level_o));

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_strobe_o |=> !data_strobe_o);

  // R7
  release_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_stretch_o) |-> data_strobe_o);

  // R8
  turn_on_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on_req_o |-> (data_strobe_o && level_o != LVL_OFF));

  // R2
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_stretch_o |-> (cnt_q == '0));

endmodule

// File: tb/pwr_recycle_ctrl_tb.sv
module pwr_recycle_ctrl_tb;
  localparam int NF = 3;
  localparam int HOLD = 20;

  logic clk = 0, rst_n = 0;
  logic [NF-1:0] flt = '0;
  logic c_hi = 0, c_md = 0, c_lo = 0, c_off = 0, bk = 0;
  logic st, clr, stb, ton;
  logic [1:0] lvl;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  pwr_recycle_ctrl #(.NUM_FAULTS(NF), .HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_fault_i(flt),
    .cmd_high_i(c_hi), .cmd_med_i(c_md), .cmd_low_i(c_lo), .cmd_off_i(c_off),
    .backup_ok_i(bk), .fault_stretch_o(st), .data_clear_o(clr),
    .data_strobe_o(stb), .turn_on_req_o(ton), .level_o(lvl));

  // behavioural reference
  int f_q[$], c_q[$];
  int m_cnt = HOLD, m_lvl = 0;
  bit m_hold = 1, m_prev = 1;
  bit m_out, m_raw;
  int cmdv;

  always @(posedge clk) begin
    if (!rst_n) begin
      f_q = {0, 0}; c_q = {0, 0};
      m_cnt = HOLD; m_hold = 1; m_prev = 1;
      if (!bk) m_lvl = 0;
    end else begin
      m_raw = (f_q[0] != 0);
      cmdv = c_q[0];
      m_out = m_raw | m_hold;
      if (!m_out) begin
        if (cmdv & 8) m_lvl = 0;
        else if (cmdv & 4) m_lvl = 3;
        else if (cmdv & 2) m_lvl = 2;
        else if (cmdv & 1) m_lvl = 1;
      end
      if (m_raw) begin m_cnt = HOLD; m_hold = 1; end
      else if (m_cnt > 0) begin m_hold = (m_cnt != 1); m_cnt--; end
      m_prev = m_out;
      void'(f_q.pop_front()); f_q.push_back(int'(|flt));
      void'(c_q.pop_front()); c_q.push_back(int'({c_off, c_hi, c_md, c_lo}));
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit e_out, e_stb;
    e_out = (f_q[0] != 0) | m_hold;
    e_stb = m_prev & ~e_out;
    chk("R1/R2/R3 stretch", int'(st), int'(e_out));
    chk("R6 clear", int'(clr), int'(e_out));
    chk("R7 strobe", int'(stb), int'(e_stb));
    chk("R8 turn_on", int'(ton), int'(e_stb && m_lvl != 0));
    chk("R4/R5/R9 level", int'(lvl), m_lvl);
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure_release(output int n, output bit s, output bit t);
    n = 0;
    while (st) begin @(negedge clk); n++; end
    s = stb; t = ton;
  endtask

  initial begin
    int n; bit s, t;
    bk = 0; rst_n = 0;
    cyc(3);
    chk("R9 reset clear", int'(clr), 1);
    chk("R9 reset level off", int'(lvl), 0);
    chk("R7 no strobe in reset", int'(stb), 0);
    rst_n = 1;
    @(negedge clk);
    measure_release(n, s, t);
    chk("R2 power-up hold length", n + 1, HOLD);
    chk("R7 strobe at release", int'(s), 1);
    chk("R8 no turn-on with level off", int'(t), 0);
    @(negedge clk);
    chk("R7 strobe one cycle", int'(stb), 0);

    c_lo = 1; cyc(1); c_lo = 0; cyc(3);
    chk("R5 LOW stored", int'(lvl), 1);
    c_md = 1; c_hi = 1; cyc(1); c_md = 0; c_hi = 0; cyc(3);
    chk("R5 HIGH over MEDIUM", int'(lvl), 3);
    c_md = 1; c_off = 1; cyc(1); c_md = 0; c_off = 0; cyc(3);
    chk("R5 OFF highest", int'(lvl), 0);
    c_hi = 1; cyc(1); c_hi = 0; cyc(3);
    chk("R5 HIGH stored", int'(lvl), 3);

    flt = 3'b100; cyc(1);
    chk("R1 not yet after one edge", int'(st), 0);
    cyc(1);
    chk("R1 stretch after two edges", int'(st), 1);
    c_lo = 1; cyc(4); c_lo = 0;
    chk("R4 command ignored in fault", int'(lvl), 3);
    flt = '0; cyc(5);
    c_off = 1; cyc(2); c_off = 0;
    chk("R4 OFF ignored in hold", int'(lvl), 3);
    flt = 3'b001; cyc(1); flt = '0;
    cyc(2);
    measure_release(n, s, t);
    chk("R3 restart full hold", n, HOLD);
    chk("R8 turn-on at release", int'(t), 1);
    chk("R4 level kept through fault", int'(lvl), 3);
    @(negedge clk);
    chk("R8 turn-on one cycle", int'(ton), 0);

    bk = 1; rst_n = 0; cyc(3);
    chk("R9 level retained", int'(lvl), 3);
    rst_n = 1; @(negedge clk);
    measure_release(n, s, t);
    chk("R9 retained level recycles", int'(t), 1);

    bk = 0; rst_n = 0; cyc(3);
    chk("R9 backup lost clears level", int'(lvl), 0);
    rst_n = 1; cyc(HOLD + 5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++; n_cmp++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule